// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter Slice

This block is a narrow binary up-counter slice, four bits wide by default. Each edge of the clock does exactly one of four things: it clears the register, loads a parallel word, adds one, or keeps the current value. The clear and the load both act on the clock edge, never in between. A load happens whatever the two count enables are doing.

The slice has two count enables with different jobs. The first, `en_count`, gates counting only. The second, `en_chain`, gates counting and also gates the terminal carry output. To build an n-bit counter from several slices, share `en_count` across all of them and feed each slice's `carry_out` into the `en_chain` of the next slice up. The carry is combinational, so a slice knows whether it will advance as soon as every lower slice has settled at all ones. It does not wait for a ripple through registers.

Top module: `casc_counter`

## Requirements
- R1: While `sclr_n` is 0 at a rising clock edge, `count` becomes 0 after that edge. This clear wins over a load and over counting.
- R2: While `sclr_n` is 1 and `load_n` is 0 at a rising edge, `count` takes the value of `load_val` after that edge.
- R3: The load of R2 happens whatever the values of `en_count` and `en_chain`, including when both are 0.
- R4: When `sclr_n` and `load_n` are both 1 and `en_count` and `en_chain` are both 1, `count` increases by one at the edge.
- R5: Counting from all ones (15 for the default width) gives 0 on the next edge.
- R6: When `sclr_n` and `load_n` are both 1 and either enable is 0, `count` keeps its value across the edge.
- R7: `carry_out` is 1 exactly when `en_chain` is 1 and `count` is all ones. It follows these inputs with no clock, and `en_count` has no effect on it.
- R8: With two slices chained (lower `carry_out` driving upper `en_chain`, with `en_count`, `sclr_n` and `load_n` shared), the pair counts, loads and clears as one counter of twice the width. The lower slice holds the low bits.
- R9: Driving `sclr_n` low between clock edges leaves `count` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Every register bit updates on the rising edge |
| sclr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_count | input | 1 | Count enable that gates counting only |
| en_chain | input | 1 | Count enable that also gates `carry_out` |
| load_val | input | WIDTH | Parallel word copied into the count on a load |
| count | output | WIDTH | Current counter value |
| carry_out | output | 1 | Terminal carry: `en_chain` AND count is all ones |

## Verification
A wrong value in the register appears on `count` at the first rising edge after the fault. Because every later increment builds on the stored value, the error then stays in place until the next load or clear. A fault in the all-ones prefix chain shows up on `carry_out` straight away, in the same cycle. In a chained pair it also appears one edge later as a missed or extra step in the upper slice, and the bench catches this by watching the 8-bit value across every low-nibble wrap.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } ctr_op_e;

    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic en_count;
        logic en_chain;
    } ctr_ctl_s;

    // Clear beats load, load beats count, count needs both enables.
    function automatic ctr_op_e pick_op(input ctr_ctl_s c);
        if (!c.clr_n)
            return OP_CLEAR;
        else if (!c.load_n)
            return OP_LOAD;
        else if (c.en_count && c.en_chain)
            return OP_COUNT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/ctr_op_sel.sv
module ctr_op_sel
    import ctr_pkg::*;
(
    input  ctr_ctl_s ctl,
    output ctr_op_e  op
);

    always_comb begin
        op = pick_op(ctl);
    end

endmodule

// File: rtl/ctr_lookahead.sv
module ctr_lookahead #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_chain,
    output logic [WIDTH-1:0] q_inc,
    output logic             term_carry
);

    // ones_below[i] is 1 when bits 0..i-1 are all 1. The same chain
    // gives the increment toggles and the terminal detect.
    logic [WIDTH:0] ones_below;

    assign ones_below[0] = 1'b1;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign ones_below[i+1] = ones_below[i] & q[i];
            assign q_inc[i]        = q[i] ^ ones_below[i];
        end
    endgenerate

    assign term_carry = en_chain & ones_below[WIDTH];

endmodule

// File: rtl/ctr_state.sv
module ctr_state
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  ctr_op_e          op,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] inc_val,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        case (op)
            OP_CLEAR: q <= '0;
            OP_LOAD:  q <= load_val;
            OP_COUNT: q <= inc_val;
            default:  q <= q;
        endcase
    end

endmodule

// File: rtl/casc_counter.sv
module casc_counter
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             sclr_n,
    input  logic             load_n,
    input  logic             en_count,
    input  logic             en_chain,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    ctr_ctl_s         ctl;
    ctr_op_e          op;
    logic [WIDTH-1:0] inc_val;

    assign ctl = '{clr_n: sclr_n, load_n: load_n,
                   en_count: en_count, en_chain: en_chain};

    ctr_op_sel u_op_sel (
        .ctl (ctl),
        .op  (op)
    );

    ctr_lookahead #(.WIDTH(WIDTH)) u_lookahead (
        .q          (count),
        .en_chain   (en_chain),
        .q_inc      (inc_val),
        .term_carry (carry_out)
    );

    ctr_state #(.WIDTH(WIDTH)) u_state (
        .clk      (clk),
        .op       (op),
        .load_val (load_val),
        .inc_val  (inc_val),
        .q        (count)
    );

    // Assertions start once the register has been cleared at least once.
    logic chk_primed = 1'b0;
    always_ff @(posedge clk) begin
        if (!sclr_n)
            chk_primed <= 1'b1;
    end

    a_r1_clear: assert property (@(posedge clk) disable iff (!chk_primed)
        !sclr_n |=> count == '0);

    a_r2_load: assert property (@(posedge clk) disable iff (!chk_primed)
        (sclr_n && !load_n) |=> count == $past(load_val));

    a_r3_load_no_enable: assert property (@(posedge clk) disable iff (!chk_primed)
        (sclr_n && !load_n && !en_count && !en_chain) |=> count == $past(load_val));

    a_r4_step: assert property (@(posedge clk) disable iff (!chk_primed)
        (sclr_n && load_n && en_count && en_chain && count != ALL_ONES)
        |=> count == WIDTH'($past(count) + 1'b1));

    a_r5_wrap: assert property (@(posedge clk) disable iff (!chk_primed)
        (sclr_n && load_n && en_count && en_chain && count == ALL_ONES)
        |=> count == '0);

    a_r6_hold: assert property (@(posedge clk) disable iff (!chk_primed)
        (sclr_n && load_n && !(en_count && en_chain)) |=> $stable(count));

    a_r7_gated: assert property (@(posedge clk) disable iff (!chk_primed)
        !en_chain |-> !carry_out);

    a_r7_next_zero: assert property (@(posedge clk) disable iff (!chk_primed)
        (carry_out && en_count && sclr_n && load_n) |=> count == '0);

endmodule

// File: tb/test_casc_counter.sv
module test_casc_counter;

    logic       clk = 1'b0;
    logic       sclr_n = 1'b1;
    logic       load_n = 1'b1;
    logic       en_count = 1'b0;
    logic       chain_in = 1'b0;
    logic [7:0] data8 = 8'h00;
    logic [3:0] q_lo, q_hi;
    logic       carry_lo, carry_hi;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] model = 8'h00;

    always #5 clk = ~clk;

    casc_counter #(.WIDTH(4)) i_casc_counter (
        .clk(clk), .sclr_n(sclr_n), .load_n(load_n), .en_count(en_count),
        .en_chain(chain_in), .load_val(data8[3:0]),
        .count(q_lo), .carry_out(carry_lo)
    );

    casc_counter #(.WIDTH(4)) i_casc_counter_hi (
        .clk(clk), .sclr_n(sclr_n), .load_n(load_n), .en_count(en_count),
        .en_chain(carry_lo), .load_val(data8[7:4]),
        .count(q_hi), .carry_out(carry_hi)
    );

    // Fields: [19] clear_n, [18] load_n, [17] en_count, [16] chain, [15:8] data, [7:0] repeats
    localparam logic [19:0] VEC [0:13] = '{
        {1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'd1},
        {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'd20},
        {1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'd3},
        {1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'd3},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'hEC, 8'd1},
        {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'd40},
        {1'b1, 1'b0, 1'b1, 1'b1, 8'hFD, 8'd1},
        {1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'd2},
        {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'd2},
        {1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'd1},
        {1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'd1},
        {1'b0, 1'b0, 1'b1, 1'b1, 8'h55, 8'd1},
        {1'b1, 1'b0, 1'b1, 1'b1, 8'h2F, 8'd1},
        {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'd3}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Called just after a falling edge: drive, let the rising edge pass, check.
    task automatic step(input bit c, input bit l, input bit e, input bit ch, input logic [7:0] d);
        string tag;
        sclr_n = c; load_n = l; en_count = e; chain_in = ch; data8 = d;
        if (!c)                        tag = "R1";
        else if (!l)                   tag = (!e && !ch) ? "R3" : "R2";
        else if (e && ch) begin
            if (model == 8'hFF)             tag = "R5";
            else if (model[3:0] == 4'hF)    tag = "R8";
            else                            tag = "R4";
        end
        else                           tag = "R6";
        @(posedge clk);
        if (!c)            model = 8'h00;
        else if (!l)       model = d;
        else if (e && ch)  model = model + 8'd1;
        #2;
        check(tag, {q_hi, q_lo}, model);
        check("R7", {7'd0, carry_lo}, {7'd0, ch && (model[3:0] == 4'hF)});
        check("R8", {7'd0, carry_hi}, {7'd0, ch && (model == 8'hFF)});
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        for (int v = 0; v < 14; v++) begin
            for (int r = 0; r < int'(VEC[v][7:0]); r++) begin
                step(VEC[v][19], VEC[v][18], VEC[v][17], VEC[v][16], VEC[v][15:8]);
            end
        end

        // R9: clear driven mid-cycle acts only at the next rising edge.
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'hA6);
        sclr_n = 1'b0; load_n = 1'b1;
        #2;
        check("R9", {q_hi, q_lo}, 8'hA6);
        @(posedge clk);
        #2;
        check("R1", {q_hi, q_lo}, 8'h00);
        model = 8'h00;
        @(negedge clk);

        // R7: carry follows en_chain with no clock edge.
        step(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF);
        chain_in = 1'b0;
        #1;
        check("R7", {7'd0, carry_lo}, 8'h00);
        chain_in = 1'b1;
        #1;
        check("R7", {7'd0, carry_lo}, 8'h01);
        check("R8", {7'd0, carry_hi}, 8'h01);
        @(negedge clk);
        step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule